// File: doc/BRIEF.md
# Mailbox Send Queue Sequencer

This block sits on the host side of a byte-wide shared mailbox RAM and moves outgoing messages to a companion processor. That processor has seven channels. Each channel owns one 32-byte message buffer and one state byte. A channel buffer holds only one message at a time, so the sequencer keeps a queue of waiting messages for each channel. The queue entries come from a pool of eight descriptor slots shared by all channels. A message is written into its channel buffer only when the channel's state byte reads idle. After the buffer is written, the state byte is set to new and the doorbell is raised.

When the interrupt logic outside the block pulses `scan_req`, the sequencer reads every channel state byte, starting at channel 0 and going up. For each channel that reads complete, it first writes idle back to the state byte. It then reads the 32-byte reply from the same buffer the request was written into and offers that reply on a valid/ready completion stream. When the consumer accepts the reply, the slot is freed and the next queued message for that channel is sent at once.

Requests enter on a valid/ready port. `req_ready` is high only while the engine is idle and no scan is pending. Each accepted request produces a one-cycle `resp_valid` with a result code. On the completion stream, `cpl_valid` stays high and `cpl_chan`/`cpl_data` stay unchanged until `cpl_ready` is sampled high. The whole engine waits while a reply is held back.

Top module: `mbox_send_seq`

## Requirements
- R1: After reset, `req_ready` is 1 and `cpl_valid`, `doorbell`, `mem_we` and `resp_valid` are 0.
- R2: A request is rejected with code 1 if any of these holds: the channel is 7, `present` is 0, or the length is above 32. A rejected request causes no memory write and no doorbell.
- R3: The pool has eight slots. A valid request that arrives while all eight slots hold pending messages gets code 2. A slot freed by a completion can be allocated again. A successful request gets code 0.
- R4: Sending on channel c writes 32 bytes at 0x100 + 32*c. Payload bytes at or beyond the request length are written as zero. The send then writes 0x01 (new) to the state byte at 0x1F0 + c. `doorbell` pulses in the cycle after that state write.
- R5: If a channel's state byte is not 0x00 (idle) when a request for that channel arrives, the request is queued and nothing is written to memory.
- R6: After a `scan_req` pulse, the state bytes are read for channels 0 to 6. Each channel whose state byte reads 0x03 (complete) is served.
- R7: A complete channel with a queued message has 0x00 written to its state byte before any of its reply bytes are read. The 32 reply bytes are read from that channel's own buffer and are presented on `cpl_data` (byte i at bits 8i+7..8i), with the channel number on `cpl_chan`.
- R8: While `cpl_valid` is 1 and `cpl_ready` is 0, `cpl_valid` stays 1 and `cpl_data` and `cpl_chan` do not change.
- R9: Once a reply is accepted, the next message queued for that channel is sent without any new request, following the R4 format, and messages leave each queue in arrival order.
- R10: A channel that reads complete but has nothing queued gets 0x00 written to its state byte and produces no completion.
- R11: When several channels are complete in the same scan, their completions appear in ascending channel order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| present | input | 1 | Companion processor is fitted |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_chan | input | 3 | Target channel |
| req_len | input | 6 | Payload length in bytes |
| req_data | input | 256 | Payload, byte i at bits 8i+7..8i |
| resp_valid | output | 1 | Result of the previous accepted request |
| resp_code | output | 2 | 0 ok, 1 bad argument, 2 pool full |
| scan_req | input | 1 | Pulse: re-examine all channel states |
| mem_re | output | 1 | Mailbox RAM read strobe (data one cycle later) |
| mem_we | output | 1 | Mailbox RAM write strobe |
| mem_addr | output | 12 | Mailbox RAM byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_re` |
| doorbell | output | 1 | One-cycle interrupt to the companion processor |
| cpl_valid | output | 1 | Reply available |
| cpl_ready | input | 1 | Reply consumer ready |
| cpl_chan | output | 3 | Channel of the reply |
| cpl_data | output | 256 | Reply bytes |

## Verification
The send path is tried with one request per channel. Lengths rise from 1 to 31, then a full 32-byte message and a zero-length message are added. This shows whether the zero fill follows the length and whether the buffer base follows the channel. Requests are then stacked on busy channels until the pool fills. This separates queueing, the full-pool code and the reuse of freed slots.

Completions are driven three ways: a single channel with the reply held back, three channels at once, and a complete channel with an empty queue. These cases expose wrong service order, a reply read before the idle write, loss of back-pressure, and a missing automatic follow-on send. The three rejection causes are each applied on their own.

// File: rtl/mbsq_pkg.sv
package mbsq_pkg;
  typedef enum logic [1:0] {
    SLOT_FREE  = 2'd0,
    SLOT_WAIT  = 2'd1,
    SLOT_DONE  = 2'd2,
    SLOT_UNSOL = 2'd3
  } slot_st_e;

  localparam logic [7:0] CH_IDLE = 8'h00;
  localparam logic [7:0] CH_NEW  = 8'h01;
  localparam logic [7:0] CH_RCVD = 8'h02;
  localparam logic [7:0] CH_DONE = 8'h03;

  localparam logic [1:0] RC_OK   = 2'd0;
  localparam logic [1:0] RC_ARG  = 2'd1;
  localparam logic [1:0] RC_FULL = 2'd2;

  typedef enum logic [3:0] {
    E_IDLE, E_CHK, E_CHK2, E_SEND, E_MARK, E_BELL,
    E_SRD, E_SCHK, E_CLR, E_RPLY, E_CPL, E_NXT
  } eng_e;
endpackage

// File: rtl/mbsq_pool.sv
module mbsq_pool
  import mbsq_pkg::*;
#(
  parameter int SLOTS = 8,
  parameter int SW    = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc,
  output logic          avail,
  output logic [SW-1:0] alloc_idx,
  input  logic          mark_done,
  input  logic [SW-1:0] done_idx,
  input  logic          release_i,
  input  logic [SW-1:0] rel_idx
);
  slot_st_e st [SLOTS];

  // lowest numbered unused slot wins
  always_comb begin
    avail     = 1'b0;
    alloc_idx = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (st[i] == SLOT_FREE) begin
        avail     = 1'b1;
        alloc_idx = SW'(i);
      end
    end
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)                                    st[g] <= SLOT_FREE;
      else if (alloc && alloc_idx == SW'(g))         st[g] <= SLOT_WAIT;
      else if (mark_done && done_idx == SW'(g))      st[g] <= SLOT_DONE;
      else if (release_i && rel_idx == SW'(g))       st[g] <= SLOT_FREE;
    end
  end

  // R3
  alloc_has_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> avail);
  // R3
  release_of_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    release_i |-> st[rel_idx] == SLOT_DONE);
  // R7
  done_of_waiting_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mark_done |-> st[done_idx] == SLOT_WAIT);
endmodule

// File: rtl/mbsq_queues.sv
module mbsq_queues #(
  parameter int CH    = 7,
  parameter int SLOTS = 8,
  parameter int CW    = 3,
  parameter int SW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [CW-1:0] push_ch,
  input  logic [SW-1:0] push_slot,
  input  logic          pop,
  input  logic [CW-1:0] sel_ch,
  output logic          sel_valid,
  output logic [SW-1:0] sel_head
);
  logic          qv [CH];
  logic [SW-1:0] hd [CH];
  logic [SW-1:0] tl [CH];
  logic [SW-1:0] nx [SLOTS];
  logic          nv [SLOTS];

  assign sel_valid = qv[sel_ch];
  assign sel_head  = hd[sel_ch];

  for (genvar c = 0; c < CH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        qv[c] <= 1'b0;
        hd[c] <= '0;
        tl[c] <= '0;
      end else if (push && push_ch == CW'(c)) begin
        if (!qv[c]) begin
          hd[c] <= push_slot;
          qv[c] <= 1'b1;
        end
        tl[c] <= push_slot;
      end else if (pop && sel_ch == CW'(c)) begin
        if (nv[hd[c]]) hd[c] <= nx[hd[c]];
        else           qv[c] <= 1'b0;
      end
    end
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_link
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        nx[s] <= '0;
        nv[s] <= 1'b0;
      end else if (push && qv[push_ch] && tl[push_ch] == SW'(s)) begin
        nx[s] <= push_slot;
        nv[s] <= 1'b1;
      end else if (push && push_slot == SW'(s)) begin
        nv[s] <= 1'b0;
      end
    end
  end

  // R9
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> sel_valid);
  // R5
  push_pop_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && pop));
endmodule

// File: rtl/mbox_send_seq.sv
module mbox_send_seq
  import mbsq_pkg::*;
#(
  parameter int             CH         = 7,
  parameter int             SLOTS      = 8,
  parameter int             MSG_BYTES  = 32,
  parameter int             AW         = 12,
  parameter logic [AW-1:0]  MSG_BASE   = 12'h100,
  parameter logic [AW-1:0]  STATE_BASE = 12'h1F0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   present,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [2:0]             req_chan,
  input  logic [5:0]             req_len,
  input  logic [MSG_BYTES*8-1:0] req_data,
  output logic                   resp_valid,
  output logic [1:0]             resp_code,
  input  logic                   scan_req,
  output logic                   mem_re,
  output logic                   mem_we,
  output logic [AW-1:0]          mem_addr,
  output logic [7:0]             mem_wdata,
  input  logic [7:0]             mem_rdata,
  output logic                   doorbell,
  output logic                   cpl_valid,
  input  logic                   cpl_ready,
  output logic [2:0]             cpl_chan,
  output logic [MSG_BYTES*8-1:0] cpl_data
);
  localparam int CW = 3;
  localparam int SW = $clog2(SLOTS);
  localparam int DW = MSG_BYTES * 8;
  localparam int BW = $clog2(MSG_BYTES);

  eng_e          st;
  logic [CW-1:0] cur_ch;
  logic          scanning, scan_pend;
  logic [BW:0]   cnt;
  logic [DW-1:0] msg_mem [SLOTS];
  logic [DW-1:0] rbuf;
  logic [DW-1:0] masked;

  logic          acc, bad, ok, avail, q_valid, go_fin, cpl_take;
  logic [SW-1:0] alloc_idx, q_head;
  logic [AW-1:0] buf_addr, st_addr;

  assign req_ready = (st == E_IDLE) && !scan_pend;
  assign acc       = req_valid && req_ready;
  assign bad       = (int'(req_chan) >= CH) || !present || (int'(req_len) > MSG_BYTES);
  assign ok        = acc && !bad && avail;
  assign cpl_take  = (st == E_CPL) && cpl_ready;

  always_comb begin
    for (int i = 0; i < MSG_BYTES; i++)
      masked[i*8 +: 8] = (i < int'(req_len)) ? req_data[i*8 +: 8] : 8'h00;
  end

  mbsq_pool #(.SLOTS(SLOTS), .SW(SW)) pool_i (
    .clk(clk), .rst_n(rst_n),
    .alloc(ok), .avail(avail), .alloc_idx(alloc_idx),
    .mark_done((st == E_CLR) && q_valid), .done_idx(q_head),
    .release_i(cpl_take), .rel_idx(q_head)
  );

  mbsq_queues #(.CH(CH), .SLOTS(SLOTS), .CW(CW), .SW(SW)) queues_i (
    .clk(clk), .rst_n(rst_n),
    .push(ok), .push_ch(req_chan), .push_slot(alloc_idx),
    .pop(cpl_take), .sel_ch(cur_ch),
    .sel_valid(q_valid), .sel_head(q_head)
  );

  assign buf_addr = MSG_BASE + AW'(cur_ch) * AW'(MSG_BYTES) + AW'(cnt[BW-1:0]);
  assign st_addr  = STATE_BASE + AW'(cur_ch);

  always_comb begin
    mem_re    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (st)
      E_CHK, E_SRD: begin mem_re = 1'b1; mem_addr = st_addr; end
      E_SEND: begin
        mem_we    = 1'b1;
        mem_addr  = buf_addr;
        mem_wdata = msg_mem[q_head][int'(cnt[BW-1:0])*8 +: 8];
      end
      E_MARK: begin mem_we = 1'b1; mem_addr = st_addr; mem_wdata = CH_NEW; end
      E_CLR:  begin mem_we = 1'b1; mem_addr = st_addr; mem_wdata = CH_IDLE; end
      E_RPLY: begin mem_re = (int'(cnt) < MSG_BYTES); mem_addr = buf_addr; end
      default: ;
    endcase
  end

  assign doorbell  = (st == E_BELL);
  assign cpl_valid = (st == E_CPL);
  assign cpl_chan  = cur_ch;
  assign cpl_data  = rbuf;

  // channel finished: move to next channel of a scan, or go idle
  assign go_fin = (st == E_CHK2 && !(mem_rdata == CH_IDLE && q_valid)) ||
                  (st == E_BELL) ||
                  (st == E_SCHK && mem_rdata != CH_DONE) ||
                  (st == E_CLR  && !q_valid) ||
                  (st == E_NXT  && !q_valid);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= E_IDLE;
      cur_ch     <= '0;
      scanning   <= 1'b0;
      scan_pend  <= 1'b0;
      cnt        <= '0;
      rbuf       <= '0;
      resp_valid <= 1'b0;
      resp_code  <= RC_OK;
    end else begin
      resp_valid <= acc;
      resp_code  <= bad ? RC_ARG : (!avail ? RC_FULL : RC_OK);
      if (scan_req) scan_pend <= 1'b1;
      else if (st == E_IDLE) scan_pend <= 1'b0;
      if (ok) msg_mem[alloc_idx] <= masked;

      if (go_fin) begin
        if (scanning && cur_ch != CW'(CH - 1)) begin
          cur_ch <= cur_ch + 1'b1;
          st     <= E_SRD;
        end else begin
          scanning <= 1'b0;
          st       <= E_IDLE;
        end
      end else begin
        unique case (st)
          E_IDLE: begin
            if (scan_pend) begin
              scanning <= 1'b1;
              cur_ch   <= '0;
              st       <= E_SRD;
            end else if (ok) begin
              scanning <= 1'b0;
              cur_ch   <= req_chan;
              st       <= E_CHK;
            end
          end
          E_CHK:  st <= E_CHK2;
          E_CHK2, E_CLR, E_NXT: begin
            cnt <= '0;
            st  <= (st == E_CLR) ? E_RPLY : E_SEND;
          end
          E_SEND: begin
            cnt <= cnt + 1'b1;
            if (int'(cnt) == MSG_BYTES - 1) st <= E_MARK;
          end
          E_MARK: st <= E_BELL;
          E_SRD:  st <= E_SCHK;
          E_SCHK: st <= E_CLR;
          E_RPLY: begin
            if (cnt != '0) rbuf[(int'(cnt) - 1)*8 +: 8] <= mem_rdata;
            cnt <= cnt + 1'b1;
            if (int'(cnt) == MSG_BYTES) st <= E_CPL;
          end
          E_CPL:  if (cpl_ready) st <= E_NXT;
          default: st <= E_IDLE;
        endcase
      end
    end
  end

  // R1
  rw_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));
  // R4
  bell_after_new_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(doorbell) |-> $past(mem_we) && $past(mem_wdata) == CH_NEW);
  // R8
  cpl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid && !cpl_ready |=> cpl_valid && $stable(cpl_data) && $stable(cpl_chan));
  // R2
  reject_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_code != RC_OK |-> !mem_we && !doorbell);
endmodule

// File: tb/mbox_send_seq_tb.sv
module mbox_send_seq_tb_top;
  localparam int CH = 7;
  localparam int MB = 32;
  localparam int MSG_BASE = 'h100;
  localparam int ST_BASE  = 'h1F0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic present = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [2:0] req_chan = '0;
  logic [5:0] req_len = '0;
  logic [MB*8-1:0] req_data = '0;
  logic resp_valid;
  logic [1:0] resp_code;
  logic scan_req = 1'b0;
  logic mem_re, mem_we;
  logic [11:0] mem_addr;
  logic [7:0] mem_wdata;
  logic [7:0] mem_rdata = '0;
  logic doorbell, cpl_valid;
  logic cpl_ready = 1'b0;
  logic [2:0] cpl_chan;
  logic [MB*8-1:0] cpl_data;

  int n_chk = 0, n_err = 0, n_we = 0, n_bell = 0, ord_bad = 0, bell_bad = 0;
  logic last_new = 1'b0;
  logic [1:0] last_code;
  logic [7:0] mem [0:4095];

  always #4 clk = ~clk;

  mbox_send_seq dut_i (
    .clk(clk), .rst_n(rst_n), .present(present),
    .req_valid(req_valid), .req_ready(req_ready), .req_chan(req_chan),
    .req_len(req_len), .req_data(req_data),
    .resp_valid(resp_valid), .resp_code(resp_code), .scan_req(scan_req),
    .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .doorbell(doorbell),
    .cpl_valid(cpl_valid), .cpl_ready(cpl_ready), .cpl_chan(cpl_chan),
    .cpl_data(cpl_data)
  );

  // mailbox RAM model with ordering monitors
  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
      n_we++;
      last_new <= (int'(mem_addr) >= ST_BASE) && (mem_wdata == 8'h01);
    end
    if (mem_re) begin
      mem_rdata <= mem[mem_addr];
      if (int'(mem_addr) >= MSG_BASE && int'(mem_addr) < MSG_BASE + CH*MB)
        if (mem[ST_BASE + (int'(mem_addr) - MSG_BASE)/MB] != 8'h00) ord_bad++;
    end
    if (doorbell) begin
      n_bell++;
      if (!last_new) bell_bad++;
    end
  end

  function automatic logic [7:0] pay(int m, int i);
    return 8'((m*37 + i*11 + 5) & 255);
  endfunction
  function automatic logic [7:0] rep(int ch, int i);
    return 8'(8'hA0 ^ i ^ (ch << 4));
  endfunction

  task automatic chk(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_idle();
    repeat (2) @(negedge clk);
    while (!req_ready) @(negedge clk);
  endtask

  task automatic send(int ch, int len, int m, bit pres);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_chan = 3'(ch); req_len = 6'(len); present = pres;
    for (int i = 0; i < MB; i++) req_data[i*8 +: 8] = pay(m, i);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    present = 1'b1;
    chk("R3 resp_valid", resp_valid, 1);
    last_code = resp_code;
    wait_idle();
  endtask

  task automatic chk_buf(string req, int ch, int m, int len);
    int bad = 0;
    for (int i = 0; i < MB; i++)
      if (mem[MSG_BASE + ch*MB + i] != ((i < len) ? pay(m, i) : 8'h00)) bad++;
    chk(req, bad, 0);
    chk(req, mem[ST_BASE + ch], 8'h01);
  endtask

  task automatic mark_done(logic [6:0] mask);
    @(negedge clk);
    for (int c = 0; c < CH; c++)
      if (mask[c]) begin
        mem[ST_BASE + c] = 8'h03;
        for (int i = 0; i < MB; i++) mem[MSG_BASE + c*MB + i] = rep(c, i);
      end
    scan_req = 1'b1;
    @(negedge clk);
    scan_req = 1'b0;
  endtask

  task automatic take_cpl(string req, int ch, int hold);
    int t = 0;
    int bad = 0;
    while (!cpl_valid && t < 400) begin @(negedge clk); t++; end
    chk(req, cpl_valid, 1);
    chk(req, cpl_chan, ch);
    for (int i = 0; i < MB; i++) if (cpl_data[i*8 +: 8] != rep(ch, i)) bad++;
    chk(req, bad, 0);
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk("R8 held valid", cpl_valid, 1);
      bad = 0;
      for (int i = 0; i < MB; i++) if (cpl_data[i*8 +: 8] != rep(ch, i)) bad++;
      chk("R8 stable data", bad, 0);
    end
    cpl_ready = 1'b1;
    @(negedge clk);
    cpl_ready = 1'b0;
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=running expected=done");
    report();
  end

  initial begin
    int we0, b0, seen;
    for (int a = 0; a < 4096; a++) mem[a] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 req_ready", req_ready, 1);
    chk("R1 cpl_valid", cpl_valid, 0);
    chk("R1 doorbell", doorbell, 0);
    chk("R1 mem_we", mem_we, 0);
    chk("R1 resp_valid", resp_valid, 0);

    // R2 rejections, each cause alone
    we0 = n_we; b0 = n_bell;
    send(7, 4, 0, 1); chk("R2 chan 7", last_code, 1);
    send(1, 4, 0, 0); chk("R2 absent", last_code, 1);
    send(1, 33, 0, 1); chk("R2 len 33", last_code, 1);
    chk("R2 no write", n_we, we0);
    chk("R2 no bell", n_bell, b0);

    // R4 length / channel sweep
    for (int c = 0; c < CH; c++) begin
      send(c, c*5 + 1, c, 1);
      chk("R3 ok code", last_code, 0);
      chk_buf("R4 buffer", c, c, c*5 + 1);
      chk("R4 bell count", n_bell, b0 + c + 1);
    end
    chk("R4 bell after new", bell_bad, 0);

    // R5 queue on busy channel, then R3 pool full
    we0 = n_we;
    send(2, 32, 10, 1); chk("R5 queued code", last_code, 0);
    chk("R5 no write", n_we, we0);
    send(3, 8, 11, 1); chk("R3 full", last_code, 2);

    // R7 R8 R9 single completion with back-pressure
    b0 = n_bell;
    mark_done(7'b0000100);
    take_cpl("R7 reply ch2", 2, 3);
    wait_idle();
    chk("R7 idle before read", ord_bad, 0);
    chk_buf("R9 follow-on", 2, 10, 32);
    chk("R9 bell", n_bell, b0 + 1);

    // pool reuse: zero length message queued on ch3
    send(3, 0, 11, 1); chk("R3 reuse", last_code, 0);
    send(3, 4, 12, 1); chk("R3 full again", last_code, 2);

    // R6 R11 three channels in one scan
    mark_done(7'b0101010);
    take_cpl("R11 first ch1", 1, 0);
    take_cpl("R11 second ch3", 3, 1);
    take_cpl("R11 third ch5", 5, 0);
    wait_idle();
    chk_buf("R9 ch3 follow-on", 3, 11, 0);
    chk("R6 ch5 idle", mem[ST_BASE + 5], 8'h00);
    chk("R7 order", ord_bad, 0);

    // R10 complete with empty queue
    mark_done(7'b0000010);
    seen = 0;
    for (int k = 0; k < 80; k++) begin
      @(negedge clk);
      if (cpl_valid) seen = 1;
    end
    chk("R10 no cpl", seen, 0);
    chk("R10 idle written", mem[ST_BASE + 1], 8'h00);

    // R3 slots freed by completions: 5 in use, 3 free
    send(0, 3, 20, 1); chk("R3 reuse a", last_code, 0);
    send(0, 3, 21, 1); chk("R3 reuse b", last_code, 0);
    send(0, 3, 22, 1); chk("R3 reuse c", last_code, 0);
    send(0, 3, 23, 1); chk("R3 full d", last_code, 2);
    report();
  end
endmodule